// File: doc/BRIEF.md
# Stackless Recursive Call Header

This block is the front end of a single hardware function instance. A caller presents an argument and holds a request line high; the header registers the argument, hands it to the function body, and one clock later fires a single-cycle start pulse at the body. The body later reports completion together with a return value and a flag saying whether it wants to call itself again.

When the flag is clear, the header publishes the return value as the call result and raises ready until the caller drops its request. When the flag is set, the header turns the return value into the next argument and starts the body again. The caller sees nothing of these extra passes. No stack exists, so only tail-style recursion is supported, and nothing has to be unwound on the way out. Arguments and results are 8 bits wide by default. Reset is synchronous and active-low.

Top module: `rec_call_header`

## Requirements
- R1: While reset is applied and after it is released with no request, `call_rdy` and `body_go` are 0, and `body_arg` and `call_res` are 0.
- R2: A request (`call_trg`=1) seen while idle loads `call_arg` into `body_arg` at that clock edge. `body_go` is then high for exactly one cycle, in the cycle after the one in which `body_arg` first shows the new value.
- R3: `body_done`=1 with `body_again`=0, sampled during a call, makes `call_res` equal the sampled `body_ret` and sets `call_rdy`=1 two clock edges after the sampling edge. `call_rdy` stays 0 in between.
- R4: `body_done`=1 with `body_again`=1 leaves `call_rdy` at 0. Two edges after the sampling edge, `body_arg` equals the sampled `body_ret`, and one cycle later `body_go` pulses again.
- R5: `body_again` only matters in the cycle in which `body_done` is sampled high. A change of `body_again` in any later cycle does not alter the outcome.
- R6: Once a call has started, `call_arg` and `call_trg` are ignored until the result is delivered. Changing the argument or pulsing the request mid-call does not change the result.
- R7: `call_rdy` stays 1 for as long as `call_trg` stays 1, and no new body start occurs in that time. `call_rdy` returns to 0 one edge after `call_trg` is sampled 0.
- R8: `body_done` while no call is in progress is ignored. `call_rdy`, `body_go` and `call_res` do not change.
- R9: With a body that returns 86 for 68, returns 13 for arguments above 12, re-calls itself with the argument minus 2 for arguments above 1, and otherwise returns the argument, every 8-bit argument yields the value of that recursive function. In particular, 68, 14, 7 and 68 give 86, 13, 1 and 86.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| call_trg | input | 1 | Caller request, held until ready is seen |
| call_arg | input | DATA_W | Caller argument |
| call_rdy | output | 1 | Result valid, held while the request stays high |
| call_res | output | DATA_W | Call result |
| body_arg | output | DATA_W | Argument presented to the function body |
| body_go | output | 1 | One-cycle start pulse to the body |
| body_ret | input | DATA_W | Return value from the body, valid with `body_done` |
| body_again | input | 1 | Recursion demand from the body, valid with `body_done` |
| body_done | input | 1 | Body completion strobe |

## Verification
The hardest situation to bring about is a recursion flag that changes after completion has been taken, or a completion that arrives while no call is in progress. A well-behaved body never produces either. The bench therefore switches its behavioural body off for those cases and drives the completion lines cycle by cycle: it raises the flag one cycle late, and it strobes completion in the idle state. Beyond those cases, a sweep over all 256 arguments uses a body latency that depends on the argument. This exercises recursion chains of up to six passes with varying gaps between them.

// File: rtl/rch_pkg.sv
// Shared types for the recursive call header.
package rch_pkg;
    // Control states, in call order.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a caller request
        ST_PREP = 3'd1,   // argument register just loaded
        ST_FIRE = 3'd2,   // start pulse to the body
        ST_BUSY = 3'd3,   // body running, waiting for completion
        ST_EVAL = 3'd4,   // completion latched, decide return or repeat
        ST_DONE = 3'd5    // result presented, waiting for request release
    } rch_state_e;
endpackage

// File: rtl/rch_ctrl.sv
// Handshake controller of the call header.
// Walks a call through load, start, wait and evaluate. It loops back to load
// when the latched recursion flag is set, and holds ready until the caller lets go.
// Assumes body_done arrives only after a start pulse. A strobe at any other time is dropped.
module rch_ctrl
    import rch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       call_trg,
    input  logic       body_done,
    input  logic       again_q,
    output logic       ld_call,
    output logic       cap_ret,
    output logic       ld_fb,
    output logic       ld_res,
    output logic       go_o,
    output logic       rdy_o
);
    rch_state_e state_q, state_d;

    // Next-state choice.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (call_trg)  state_d = ST_PREP;
            ST_PREP:                state_d = ST_FIRE;
            ST_FIRE:                state_d = ST_BUSY;
            ST_BUSY: if (body_done) state_d = ST_EVAL;
            ST_EVAL:                state_d = again_q ? ST_PREP : ST_DONE;
            ST_DONE: if (!call_trg) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Register load strobes and handshake outputs decoded from the state.
    always_comb begin
        ld_call = (state_q == ST_IDLE) && call_trg;
        cap_ret = (state_q == ST_BUSY) && body_done;
        ld_fb   = (state_q == ST_EVAL) && again_q;
        ld_res  = (state_q == ST_EVAL) && !again_q;
        go_o    = (state_q == ST_FIRE);
        rdy_o   = (state_q == ST_DONE);
    end

    // R2: the start pulse lasts one cycle.
    p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !go_o);
    // R2: the start pulse follows the argument load by one cycle.
    p_go_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(state_q) == ST_PREP);
    // R4: a recursion pass never raises ready.
    p_no_rdy_on_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && again_q) |=> !rdy_o);
    // R7: ready is held while the request is held.
    p_rdy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && call_trg) |=> (rdy_o && !go_o));
    // R7: ready drops once the request is released.
    p_rdy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !call_trg) |=> !rdy_o);
endmodule

// File: rtl/rch_regs.sv
// Data registers of the call header: argument, latched return value,
// latched recursion flag and published result.
// The argument register takes either the caller's argument or the looped-back
// return value. The controller never asserts both loads in one cycle.
module rch_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_call,
    input  logic              cap_ret,
    input  logic              ld_fb,
    input  logic              ld_res,
    input  logic [DATA_W-1:0] call_arg,
    input  logic [DATA_W-1:0] body_ret,
    input  logic              body_again,
    output logic [DATA_W-1:0] arg_q,
    output logic              again_q,
    output logic [DATA_W-1:0] res_q
);
    logic [DATA_W-1:0] ret_q;

    // Argument register: caller value on a new call, return value on recursion.
    always_ff @(posedge clk) begin
        if (!rst_n)       arg_q <= '0;
        else if (ld_call) arg_q <= call_arg;
        else if (ld_fb)   arg_q <= ret_q;
    end

    // Capture of return value and recursion flag at body completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q   <= '0;
            again_q <= 1'b0;
        end else if (cap_ret) begin
            ret_q   <= body_ret;
            again_q <= body_again;
        end
    end

    // Result register toward the caller.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (ld_res) res_q <= ret_q;
    end

    // R6: the argument register changes only on a load strobe.
    p_arg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_call || ld_fb) |=> $stable(arg_q));
    // R6: a new call and a loop-back never coincide.
    p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_call && ld_fb));
    // R5: the recursion flag changes only at completion capture.
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ret |=> $stable(again_q));
    // R8: the result changes only when a non-recursive return is published.
    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_res |=> $stable(res_q));
endmodule

// File: rtl/rec_call_header.sv
// Stackless recursive call header: top level.
// Joins the handshake controller and the data registers. The body is external.
// Assumes the body holds body_ret and body_again valid in the cycle body_done is high.
module rec_call_header #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_trg,
    input  logic [DATA_W-1:0] call_arg,
    output logic              call_rdy,
    output logic [DATA_W-1:0] call_res,
    output logic [DATA_W-1:0] body_arg,
    output logic              body_go,
    input  logic [DATA_W-1:0] body_ret,
    input  logic              body_again,
    input  logic              body_done
);
    logic ld_call, cap_ret, ld_fb, ld_res, again_q;

    // Sequencing of a call and its recursive passes.
    rch_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_trg  (call_trg),
        .body_done (body_done),
        .again_q   (again_q),
        .ld_call   (ld_call),
        .cap_ret   (cap_ret),
        .ld_fb     (ld_fb),
        .ld_res    (ld_res),
        .go_o      (body_go),
        .rdy_o     (call_rdy)
    );

    // Argument, return and result storage.
    rch_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_call    (ld_call),
        .cap_ret    (cap_ret),
        .ld_fb      (ld_fb),
        .ld_res     (ld_res),
        .call_arg   (call_arg),
        .body_ret   (body_ret),
        .body_again (body_again),
        .arg_q      (body_arg),
        .again_q    (again_q),
        .res_q      (call_res)
    );

    // R3: ready never coincides with a body start.
    p_rdy_no_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        call_rdy |-> !body_go);
endmodule

// File: tb/tb_rec_call_header.sv
// Self-checking bench for rec_call_header with a behavioural recursive body.
module tb_rec_call_header;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_trg = 1'b0;
    logic [DW-1:0] call_arg = '0;
    logic          call_rdy;
    logic [DW-1:0] call_res;
    logic [DW-1:0] body_arg;
    logic          body_go;
    logic [DW-1:0] body_ret = '0;
    logic          body_again = 1'b0;
    logic          body_done = 1'b0;
    logic          model_on = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rec_call_header #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .call_trg(call_trg), .call_arg(call_arg),
        .call_rdy(call_rdy), .call_res(call_res), .body_arg(body_arg),
        .body_go(body_go), .body_ret(body_ret), .body_again(body_again),
        .body_done(body_done)
    );

    // Reference value of the whole recursive function.
    function automatic int ref_f(int n);
        int v = n;
        while (1) begin
            if (v == 68) return 86;
            if (v > 12)  return 13;
            if (v > 1)   v = v - 2;
            else         return v;
        end
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural body: one pass per start pulse, latency from argument.
    initial begin
        forever begin
            @(negedge clk);
            if (model_on && body_go) begin
                automatic int n = int'(body_arg);
                repeat (1 + n % 4) @(negedge clk);
                if (n == 68)     begin body_ret = 8'd86; body_again = 1'b0; end
                else if (n > 12) begin body_ret = 8'd13; body_again = 1'b0; end
                else if (n > 1)  begin body_ret = DW'(n - 2); body_again = 1'b1; end
                else             begin body_ret = DW'(n); body_again = 1'b0; end
                body_done = 1'b1;
                @(negedge clk);
                body_done = 1'b0;
                body_again = 1'b0;
            end
        end
    end

    task automatic wait_rdy(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (call_rdy) begin ok = 1'b1; break; end
        end
    endtask

    // Full call through the behavioural body, checks result and release.
    task automatic do_call(input int a, input string tag);
        bit ok;
        call_arg = DW'(a);
        call_trg = 1'b1;
        wait_rdy(ok);
        chk({tag, " ready"}, int'(ok), 1);
        chk({tag, " result"}, int'(call_res), ref_f(a));
        call_trg = 1'b0;
        @(negedge clk);
        chk("R7 ready drop", int'(call_rdy), 0);
    endtask

    initial begin
        bit ok;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 rdy in reset", int'(call_rdy), 0);
        chk("R1 go in reset", int'(body_go), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rdy idle", int'(call_rdy), 0);
        chk("R1 arg idle", int'(body_arg), 0);
        chk("R1 res idle", int'(call_res), 0);

        // R2 and R4 with a hand-driven body.
        call_arg = 8'd5; call_trg = 1'b1;
        @(negedge clk);
        chk("R2 arg loaded", int'(body_arg), 5);
        chk("R2 go not yet", int'(body_go), 0);
        @(negedge clk);
        chk("R2 go pulse", int'(body_go), 1);
        @(negedge clk);
        chk("R2 go single", int'(body_go), 0);
        body_ret = 8'd9; body_again = 1'b1; body_done = 1'b1;
        @(negedge clk);
        body_done = 1'b0; body_again = 1'b0;
        chk("R4 no rdy eval", int'(call_rdy), 0);
        @(negedge clk);
        chk("R4 arg looped", int'(body_arg), 9);
        chk("R4 no rdy prep", int'(call_rdy), 0);
        @(negedge clk);
        chk("R4 go again", int'(body_go), 1);
        @(negedge clk);
        // R5 and R3: flag rises one cycle late and must be ignored.
        body_ret = 8'h21; body_again = 1'b0; body_done = 1'b1;
        @(negedge clk);
        body_done = 1'b0; body_again = 1'b1;
        chk("R3 rdy after one edge", int'(call_rdy), 0);
        @(negedge clk);
        body_again = 1'b0;
        chk("R3 rdy after two edges", int'(call_rdy), 1);
        chk("R3 result", int'(call_res), 'h21);
        chk("R5 late flag no go", int'(body_go), 0);
        // R7: hold request, ready stays and nothing restarts.
        repeat (4) begin
            @(negedge clk);
            chk("R7 rdy held", int'(call_rdy), 1);
            chk("R7 no restart", int'(body_go), 0);
        end
        call_trg = 1'b0;
        @(negedge clk);
        chk("R7 rdy released", int'(call_rdy), 0);

        // R8: stray completion while idle.
        body_ret = 8'hAA; body_done = 1'b1;
        @(negedge clk);
        body_done = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R8 rdy idle", int'(call_rdy), 0);
            chk("R8 go idle", int'(body_go), 0);
            chk("R8 res kept", int'(call_res), 'h21);
        end

        // R9: named sequence, then the full sweep.
        model_on = 1'b1;
        do_call(68, "R9 68");
        do_call(14, "R9 14");
        do_call(7, "R9 7");
        do_call(68, "R9 68 again");
        chk("R9 last value", int'(call_res), 86);

        // R6: disturb argument and request mid-call.
        call_arg = 8'd11; call_trg = 1'b1;
        repeat (3) @(negedge clk);
        call_arg = 8'd68; call_trg = 1'b0;
        @(negedge clk);
        call_trg = 1'b1;
        wait_rdy(ok);
        chk("R6 ready", int'(ok), 1);
        chk("R6 result unaffected", int'(call_res), 1);
        call_trg = 1'b0;
        @(negedge clk);

        for (int a = 0; a < 256; a++) do_call(a, "R9 sweep");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule